// File: doc/BRIEF.md
# PS/2 Host Port Register Front End

This block is the processor-facing half of a PS/2 keyboard or mouse port. It sits on a simple word-addressed peripheral bus inside a 4 KB window. Software uses it to program a control word and a clock divisor, to read received bytes, to send bytes, and to see status and interrupt state. A read-only identification window fills the top 32 bytes of the region. The line-level PS/2 shifter is a separate block. It hands each received byte over as a one-cycle valid strobe with data. It takes each byte to send as a one-cycle transmit strobe.

The front end holds the most recent received byte and a pending flag. It also keeps the byte that the last data read returned, and a live parity bit of that byte. One interrupt line combines two sources. The first is a pending byte, gated by one control bit. The second is a second control bit that raises the line on its own, because the transmitter always reports that it is empty. The divisor is only stored for the serialiser and read back.

Top module: `ps2_host_regs`

## Requirements
- R1: After a synchronous active-low reset, control, divisor, pending flag and last-read byte are zero. `irq`, `dev_tx_stb` and `bus_err` are low.
- R2: Word index 0 (control, CTRL_W bits) and word index 3 (divisor, DIV_W bits) store the low bits of a write and read them back. All higher read bits are zero.
- R3: Word index 1 (status) reads bit 6 = 1 (transmit empty), bit 4 = pending, and bit 2 = XOR of all bits of the last-read byte. Every other bit reads 0.
- R4: A read of word index 2 (data) with a byte pending returns that byte, makes it the last-read byte and clears pending. Without a pending byte the read returns the last-read byte again.
- R5: A device byte with `dev_rx_valid` sets pending and replaces any pending byte. If it arrives in the same cycle as a consuming data read, the read returns the older byte and the new byte stays pending.
- R6: `irq` = (pending AND control bit 4) OR control bit 3. It follows the registered state, one cycle after a control write or a pending change.
- R7: Word index 4 (interrupt status) reads bit 0 = pending and bit 1 = 1, with the other bits 0.
- R8: A read at byte offsets 0xFE0 to 0xFFC returns identification byte k = (offset - 0xFE0) >> 2. Byte k is taken from bits 8k+7:8k of ID_VALUE.
- R9: A write to word index 2 produces a one-cycle `dev_tx_stb` in the cycle after the write, with `dev_tx_byte` equal to write data bits 7:0. A divisor write produces no strobe.
- R10: An access to any other offset reads zero and changes no state. `bus_err` pulses for one cycle. A write to status, interrupt status or the identification window is ignored and raises no error.
- R11: `bus_rdata` is registered and valid in the cycle after a read. Byte-address bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address within the window |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, one cycle after the access |
| bus_err | output | 1 | One-cycle pulse for an undefined offset |
| dev_rx_valid | input | 1 | Received byte strobe from the deserialiser |
| dev_rx_byte | input | 8 | Received byte |
| dev_tx_stb | output | 1 | Byte-to-send strobe to the serialiser |
| dev_tx_byte | output | 8 | Byte to send |
| irq | output | 1 | Combined interrupt |

## Verification
A wrong pending flag shows up on the first status, interrupt status or data read after it. It also reaches `irq` in the very next cycle whenever control bit 4 is set. A wrong last-read byte can stay hidden until a data read with nothing pending, or until the status parity bit is read. For that reason the bench reads status after every consumed byte and repeats data reads with no byte pending. The arrival of a byte in the same cycle as a consuming read is driven on purpose, because only a second read exposes a lost byte.

// File: rtl/ps2_regs_pkg.sv
// Shared definitions for the PS/2 host register front end.
// Assumes a word-addressed bus where word index = byte address >> 2.
package ps2_regs_pkg;
    typedef enum logic [2:0] {
        WIX_CTRL = 3'd0,
        WIX_STAT = 3'd1,
        WIX_DATA = 3'd2,
        WIX_DIV  = 3'd3,
        WIX_IRQS = 3'd4
    } word_ix_e;

    localparam int unsigned ST_TX_EMPTY = 6;
    localparam int unsigned ST_RX_FULL  = 4;
    localparam int unsigned ST_RX_PAR   = 2;
    localparam int unsigned CR_RX_IE    = 4;
    localparam int unsigned CR_TX_IE    = 3;
    localparam int unsigned BYTE_W      = 8;
    localparam int unsigned ID_COUNT    = 8;
endpackage

// File: rtl/ps2_bus_decode.sv
// Address decoder: turns one bus cycle into per-register strobes.
// Assumes the identification window is the top 32 bytes of a 2**ADDR_W region.
module ps2_bus_decode
    import ps2_regs_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output logic              rd_any,
    output logic              wr_ctrl,
    output logic              wr_data,
    output logic              wr_div,
    output logic              rd_data,
    output logic              id_hit,
    output logic [2:0]        id_idx,
    output logic [2:0]        word_lo,
    output logic              bad_acc
);
    localparam int unsigned WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    logic              known;
    logic              unused_addr;

    assign word        = addr[ADDR_W-1:2];
    assign unused_addr = ^addr[1:0];

    // Classify the access against the register map.
    always_comb begin
        id_hit  = &addr[ADDR_W-1:5];
        id_idx  = addr[4:2];
        word_lo = word[2:0];
        known   = (word <= WORD_W'(WIX_IRQS)) || id_hit;
        rd_any  = sel && !wr;
        wr_ctrl = sel && wr && (word == WORD_W'(WIX_CTRL));
        wr_data = sel && wr && (word == WORD_W'(WIX_DATA));
        wr_div  = sel && wr && (word == WORD_W'(WIX_DIV));
        rd_data = sel && !wr && (word == WORD_W'(WIX_DATA));
        bad_acc = sel && !known;
    end
endmodule

// File: rtl/ps2_rx_hold.sv
// Receive holder: keeps the newest device byte, the pending flag and the
// byte last handed to the host, plus the live parity of that last byte.
// Assumes consume is asserted only for a data-register read.
module ps2_rx_hold
    import ps2_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              consume,
    output logic              pending,
    output logic [BYTE_W-1:0] read_val,
    output logic              last_par
);
    logic [BYTE_W-1:0] held_q;
    logic [BYTE_W-1:0] last_q;
    logic              pend_q;

    // Capture new bytes, hand the held byte over on a consuming read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
            last_q <= '0;
            pend_q <= 1'b0;
        end else begin
            if (consume && pend_q)
                last_q <= held_q;
            if (rx_valid) begin
                held_q <= rx_byte;
                pend_q <= 1'b1;
            end else if (consume) begin
                pend_q <= 1'b0;
            end
        end
    end

    // Fold the last byte onto itself by halving shifts down to one bit.
    always_comb begin
        logic [BYTE_W-1:0] f;
        f = last_q;
        for (int s = BYTE_W / 2; s >= 1; s = s / 2)
            f = f ^ (f >> s);
        last_par = f[0];
    end

    assign pending  = pend_q;
    assign read_val = pend_q ? held_q : last_q;

    AST_PEND_ON_RX: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> pending); // R5
    AST_PEND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (consume && !rx_valid) |=> !pending); // R4
    AST_LAST_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !consume |=> $stable(last_par)); // R3
endmodule

// File: rtl/ps2_id_window.sv
// Identification window: selects one of eight constant bytes.
// Assumes byte k of ID_VALUE sits at bits 8k+7:8k.
module ps2_id_window
    import ps2_regs_pkg::*;
#(
    parameter logic [ID_COUNT*BYTE_W-1:0] ID_VALUE = 64'hC3A55A3C00172D4E
) (
    input  logic [2:0]        idx,
    output logic [BYTE_W-1:0] id_byte
);
    logic [BYTE_W-1:0] bytes [ID_COUNT];

    for (genvar k = 0; k < ID_COUNT; k++) begin : g_id
        assign bytes[k] = ID_VALUE[k*BYTE_W +: BYTE_W];
    end

    // Pick the addressed byte.
    assign id_byte = bytes[idx];
endmodule

// File: rtl/ps2_host_regs.sv
// PS/2 host port register front end: control, status, data, divisor,
// interrupt status and an identification window on a word-addressed bus.
// Assumes single-cycle bus accesses; read data returns one cycle later.
module ps2_host_regs
    import ps2_regs_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CTRL_W = 8,
    parameter int unsigned DIV_W  = 8,
    parameter logic [ID_COUNT*BYTE_W-1:0] ID_VALUE = 64'hC3A55A3C00172D4E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err,
    input  logic              dev_rx_valid,
    input  logic [7:0]        dev_rx_byte,
    output logic              dev_tx_stb,
    output logic [7:0]        dev_tx_byte,
    output logic              irq
);
    localparam int unsigned CPAD = DATA_W - CTRL_W;
    localparam int unsigned DPAD = DATA_W - DIV_W;
    localparam int unsigned BPAD = DATA_W - BYTE_W;

    logic              rd_any, wr_ctrl, wr_data, wr_div, rd_data, id_hit, bad_acc;
    logic [2:0]        id_idx, word_lo;
    logic              pending, last_par;
    logic [BYTE_W-1:0] rx_val, id_byte;
    logic [CTRL_W-1:0] ctrl_q;
    logic [DIV_W-1:0]  div_q;
    logic [DATA_W-1:0] rd_mux;
    logic              unused_wdata;

    assign unused_wdata = ^bus_wdata;

    ps2_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
        .rd_any(rd_any), .wr_ctrl(wr_ctrl), .wr_data(wr_data), .wr_div(wr_div),
        .rd_data(rd_data), .id_hit(id_hit), .id_idx(id_idx),
        .word_lo(word_lo), .bad_acc(bad_acc)
    );

    ps2_rx_hold u_rx (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(dev_rx_valid), .rx_byte(dev_rx_byte), .consume(rd_data),
        .pending(pending), .read_val(rx_val), .last_par(last_par)
    );

    ps2_id_window #(.ID_VALUE(ID_VALUE)) u_id (
        .idx(id_idx), .id_byte(id_byte)
    );

    // Store control and divisor words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            div_q  <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= bus_wdata[CTRL_W-1:0];
            if (wr_div)  div_q  <= bus_wdata[DIV_W-1:0];
        end
    end

    // Select read data for the addressed register.
    always_comb begin
        rd_mux = '0;
        if (bad_acc) begin
            rd_mux = '0;
        end else if (id_hit) begin
            rd_mux = {{BPAD{1'b0}}, id_byte};
        end else begin
            case (word_ix_e'(word_lo))
                WIX_CTRL: rd_mux = {{CPAD{1'b0}}, ctrl_q};
                WIX_STAT: begin
                    rd_mux[ST_TX_EMPTY] = 1'b1;
                    rd_mux[ST_RX_FULL]  = pending;
                    rd_mux[ST_RX_PAR]   = last_par;
                end
                WIX_DATA: rd_mux = {{BPAD{1'b0}}, rx_val};
                WIX_DIV:  rd_mux = {{DPAD{1'b0}}, div_q};
                WIX_IRQS: rd_mux = {{(DATA_W-2){1'b0}}, 1'b1, pending};
                default:  rd_mux = '0;
            endcase
        end
    end

    // Register read data, error pulse and transmit strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata   <= '0;
            bus_err     <= 1'b0;
            dev_tx_stb  <= 1'b0;
            dev_tx_byte <= '0;
        end else begin
            if (rd_any) bus_rdata <= rd_mux;
            bus_err    <= bad_acc;
            dev_tx_stb <= wr_data && !bad_acc;
            if (wr_data) dev_tx_byte <= bus_wdata[BYTE_W-1:0];
        end
    end

    // Combine receive and transmit interrupt sources.
    assign irq = (pending && ctrl_q[CR_RX_IE]) || ctrl_q[CR_TX_IE];

    AST_TX_IRQ_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && bus_wdata[CR_TX_IE]) |=> irq); // R6
    AST_TX_STB_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        dev_tx_stb |-> $past(bus_sel && bus_wr && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(WIX_DATA)))); // R9
    AST_ERR_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_sel)); // R10
    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |=> $stable(ctrl_q)); // R2
endmodule

// File: tb/sim_ps2_host_regs.sv
module sim_ps2_host_regs;
    localparam logic [63:0] IDV = 64'hC3A55A3C00172D4E;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic        dev_rx_valid = 1'b0;
    logic [7:0]  dev_rx_byte = '0;
    logic        dev_tx_stb;
    logic [7:0]  dev_tx_byte;
    logic        irq;

    int checks = 0, errors = 0;
    bit done = 0;

    typedef struct { logic [31:0] exp; string tag; } exp_t;
    exp_t sbq[$];

    always #4 clk = ~clk;

    ps2_host_regs #(.ID_VALUE(IDV)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .dev_rx_valid(dev_rx_valid), .dev_rx_byte(dev_rx_byte),
        .dev_tx_stb(dev_tx_stb), .dev_tx_byte(dev_tx_byte), .irq(irq)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: one read, expected value pushed for the monitor.
    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
        sbq.push_back('{e, tag});
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rx(input logic [7:0] b);
        dev_rx_valid = 1'b1; dev_rx_byte = b;
        @(negedge clk);
        dev_rx_valid = 1'b0;
    endtask

    // Data read with a device byte arriving in the same cycle.
    task automatic rd_rx(input logic [31:0] e, input logic [7:0] b, input string tag);
        sbq.push_back('{e, tag});
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 12'h008;
        dev_rx_valid = 1'b1; dev_rx_byte = b;
        @(negedge clk);
        bus_sel = 1'b0; dev_rx_valid = 1'b0;
    endtask

    // Monitor: pops the scoreboard one cycle after each read.
    always @(posedge clk) begin
        exp_t it;
        logic took;
        took = bus_sel && !bus_wr && rst_n;
        #2;
        if (took) begin
            if (sbq.size() == 0) begin
                chk(32'hDEAD, 32'h0, "R11 scoreboard underflow");
            end else begin
                it = sbq.pop_front();
                chk(bus_rdata, it.exp, it.tag);
            end
        end
    end

    function automatic logic [31:0] stat(input logic pend, input logic [7:0] last);
        return 32'h40 | (pend ? 32'h10 : 32'h0) | ((^last) ? 32'h4 : 32'h0);
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports and in the registers
        chk({31'b0, irq}, 0, "R1 irq");
        chk({31'b0, dev_tx_stb}, 0, "R1 tx strobe");
        chk({31'b0, bus_err}, 0, "R1 err");
        rd(12'h000, 0, "R1 ctrl");
        rd(12'h00C, 0, "R1 divisor");
        rd(12'h004, stat(0, 8'h00), "R3 status after reset");
        rd(12'h008, 0, "R4 data with nothing pending");
        rd(12'h010, 32'h2, "R7 irq status idle");
        // R2: control readback, upper bits dropped
        wr(12'h000, 32'hFFFF_FF10);
        rd(12'h000, 32'h10, "R2 ctrl readback");
        chk({31'b0, irq}, 0, "R6 rx enable without pending");
        // R2/R9: divisor stored, no strobe
        wr(12'h00C, 32'h1234_56A5);
        chk({31'b0, dev_tx_stb}, 0, "R9 no strobe on divisor write");
        rd(12'h00C, 32'hA5, "R2 divisor readback");
        rd(12'h00D, 32'hA5, "R11 low address bits ignored");
        // R5/R6/R3/R7: byte arrives
        rx(8'h5B);
        chk({31'b0, irq}, 1, "R6 pending with rx enable");
        rd(12'h004, stat(1, 8'h00), "R3 status pending");
        rd(12'h010, 32'h3, "R7 irq status pending");
        rd(12'h008, 32'h5B, "R4 consume pending byte");
        chk({31'b0, irq}, 0, "R6 irq drops after consume");
        rd(12'h004, stat(0, 8'h5B), "R3 parity of last byte");
        rd(12'h008, 32'h5B, "R4 repeat last byte");
        // R5: overwrite while pending
        rx(8'h11);
        rx(8'h80);
        rd(12'h008, 32'h80, "R5 overwrite keeps newest");
        rd(12'h004, stat(0, 8'h80), "R3 parity after overwrite");
        // R5: arrival in the same cycle as a consuming read
        rx(8'h03);
        rd_rx(32'h03, 8'h07, "R5 same-cycle read returns older");
        rd(12'h004, stat(1, 8'h03), "R5 new byte still pending");
        rd(12'h008, 32'h07, "R5 second read returns newer");
        rd(12'h004, stat(0, 8'h07), "R3 parity odd byte");
        // R6: transmit enable forces irq
        wr(12'h000, 32'h08);
        chk({31'b0, irq}, 1, "R6 tx enable forces irq");
        wr(12'h000, 32'h00);
        chk({31'b0, irq}, 0, "R6 irq low with both disabled");
        // R8: identification window
        for (int k = 0; k < 8; k++)
            rd(12'hFE0 + 12'(4 * k), {24'b0, IDV[8*k +: 8]}, "R8 id byte");
        rd(12'hFE3, {24'b0, IDV[7:0]}, "R11 id low bits ignored");
        // R9: transmit strobe
        wr(12'h008, 32'hABCD_EF3C);
        chk({31'b0, dev_tx_stb}, 1, "R9 strobe after data write");
        chk({24'b0, dev_tx_byte}, 32'h3C, "R9 low byte sent");
        @(negedge clk);
        chk({31'b0, dev_tx_stb}, 0, "R9 strobe one cycle");
        // R10: undefined offsets
        wr(12'h00C, 32'h77);
        rd(12'h014, 0, "R10 undefined read zero");
        chk({31'b0, bus_err}, 1, "R10 err pulse on read");
        @(negedge clk);
        chk({31'b0, bus_err}, 0, "R10 err one cycle");
        wr(12'h800, 32'hFFFF_FFFF);
        chk({31'b0, bus_err}, 1, "R10 err pulse on write");
        chk({31'b0, dev_tx_stb}, 0, "R10 no strobe on bad write");
        rd(12'h000, 32'h00, "R10 ctrl untouched");
        rd(12'h00C, 32'h77, "R10 divisor untouched");
        wr(12'h004, 32'hFFFF_FFFF);
        chk({31'b0, bus_err}, 0, "R10 read-only write no error");
        chk({31'b0, irq}, 0, "R10 read-only write ignored");
        rd(12'h004, stat(0, 8'h07), "R10 status unchanged");
        repeat (3) @(negedge clk);
        chk(sbq.size(), 0, "R11 all reads answered");
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule